// File: doc/BRIEF.md
# Peripheral Multi-Word Access Splitter

The splitter sits between a load/store unit and a 32-bit peripheral port that accepts only short incrementing bursts. Each request names a start address and one of two access types. The first type is a run of one to eight aligned 32-bit words. The second is a single halfword or byte. The block turns that request into a series of address-channel transactions. Each transaction carries an address, a burst type, a transfer size and a beat count. For writes, every accepted address is followed by its data beats, each with its byte strobes and a last-beat marker.

A word run is cut into two-beat bursts that step by eight bytes. When the word count is odd, one single-beat burst closes the run. A halfword or byte always becomes one single-beat transfer, and its strobe selects the addressed byte lanes. A request that is misaligned, or that asks for an illegal word count, is refused. The refusal raises an error pulse, and nothing reaches the port. The block holds one request at a time and takes a new one only when it is idle.

Top module: `periph_burst_splitter`

## Requirements
- R1: Every address transaction carries burst type 2'b01 (incrementing), and its length field holds the beat count minus one, so it is either 0 or 1.
- R2: A word run (req_kind 2'b00) of N words at address A produces floor(N/2) two-beat bursts at A, A+8, A+16 and so on. When N is odd, a final one-beat burst follows at A+8*floor(N/2). All of these bursts use size 3'b010.
- R3: Each write beat of a word run has strobe 4'b1111. w_last is high on the final beat of each burst and low on every other beat.
- R4: A halfword (req_kind 2'b01) produces one transaction with size 3'b001 and length 0. Its strobe is 4'b0011 when address bit 1 is 0, and 4'b1100 when address bit 1 is 1. The word count is ignored.
- R5: A byte (req_kind 2'b10) produces one transaction with size 3'b000 and length 0. Its strobe has only bit A[1:0] set. The word count is ignored.
- R6: Some requests are refused: a halfword with A[0]=1, a word run with A[1:0]!=0, a word run with a count of 0 or more than 8, and the reserved kind 2'b11. A refused request raises req_err for exactly the one cycle after it is accepted, and it produces no address or data activity.
- R7: While ax_valid is high and ax_ready is low, ax_valid stays high and the address, length and size hold steady. No data beat of a burst is presented before its address is accepted. No new address is presented before every data beat of the previous write burst is accepted.
- R8: req_ready is high only while no transaction is in progress. A read (req_write low) issues no data beats. ax_write reflects the request's read/write flag.
- R9: After reset, req_ready is high, and ax_valid, w_valid and req_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | Block is idle and takes the request |
| req_addr | input | 32 | Start byte address |
| req_kind | input | 2 | 00 word run, 01 halfword, 10 byte, 11 reserved |
| req_count | input | 4 | Number of words in a word run (1 to 8) |
| req_write | input | 1 | 1 for write, 0 for read |
| req_err | output | 1 | One-cycle pulse after a refused request |
| ax_valid | output | 1 | Address transaction valid |
| ax_ready | input | 1 | Port accepts the address transaction |
| ax_addr | output | 32 | Burst start address |
| ax_burst | output | 2 | Burst type, always incrementing |
| ax_size | output | 3 | log2 of the bytes per beat |
| ax_len | output | 4 | Beats minus one |
| ax_write | output | 1 | Transaction direction |
| w_valid | output | 1 | Write data beat valid |
| w_ready | input | 1 | Port accepts the data beat |
| w_strb | output | 4 | Byte lane strobes of the beat |
| w_last | output | 1 | Final beat of the burst |

## Verification
The hold assertions assume the port follows the usual valid/ready rule. Under that rule, ready may drop at any time, and an offered address or beat stays offered until ready takes it. The bench keeps to this because it changes ax_ready and w_ready only at the falling edge, choosing them at random with several acceptance rates, and never depends on a combinational path from ready. Requests are presented only while req_ready is high. The random stream mixes aligned, misaligned and reserved requests, and word counts from 0 to 9, so both accepted and refused requests reach the checker.

// File: rtl/splitter_pkg.sv
package splitter_pkg;

    typedef enum logic [1:0] {
        KIND_WORD = 2'b00,
        KIND_HALF = 2'b01,
        KIND_BYTE = 2'b10,
        KIND_RSVD = 2'b11
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_ADDR = 2'b01,
        ST_DATA = 2'b10
    } state_e;

    localparam logic [1:0] BURST_INCR = 2'b01;

endpackage

// File: rtl/splitter_req_check.sv
// Validates a request and derives its transfer size, strobe and word total.
module splitter_req_check
    import splitter_pkg::*;
#(
    parameter int BYTES     = 4,
    parameter int MAX_WORDS = 8,
    parameter int CNT_W     = 4,
    parameter int SIZE_W    = 3,
    localparam int OFS_W    = $clog2(BYTES),
    localparam int REM_W    = $clog2(MAX_WORDS + 1)
) (
    input  logic [OFS_W-1:0]  ofs,
    input  kind_e             kind,
    input  logic [CNT_W-1:0]  count,
    output logic              ok,
    output logic [SIZE_W-1:0] size,
    output logic [BYTES-1:0]  strb,
    output logic [REM_W-1:0]  words
);

    always_comb begin
        ok    = 1'b0;
        size  = '0;
        strb  = '0;
        words = REM_W'(1);
        case (kind)
            KIND_WORD: begin
                ok    = (ofs == '0) && (count != '0) &&
                        (count <= CNT_W'(MAX_WORDS));
                size  = SIZE_W'(OFS_W);
                strb  = '1;
                words = REM_W'(count);
            end
            KIND_HALF: begin
                ok   = (ofs[0] == 1'b0);
                size = SIZE_W'(1);
                strb = BYTES'(3) << ofs;
            end
            KIND_BYTE: begin
                ok   = 1'b1;
                size = '0;
                strb = BYTES'(1) << ofs;
            end
            default: ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/splitter_fsm.sv
// Sequencer: address phase, then data beats for writes, repeated until
// the word total is used up.
module splitter_fsm
    import splitter_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BYTES     = 4,
    parameter int MAX_WORDS = 8,
    parameter int MAX_BEATS = 2,
    parameter int LEN_W     = 4,
    parameter int SIZE_W    = 3,
    localparam int OFS_W    = $clog2(BYTES),
    localparam int REM_W    = $clog2(MAX_WORDS + 1),
    localparam int BEAT_W   = $clog2(MAX_BEATS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              chk_ok,
    input  logic [SIZE_W-1:0] chk_size,
    input  logic [BYTES-1:0]  chk_strb,
    input  logic [REM_W-1:0]  chk_words,
    output logic              req_ready,
    output logic              req_err,
    output logic              ax_valid,
    input  logic              ax_ready,
    output logic [ADDR_W-1:0] ax_addr,
    output logic [1:0]        ax_burst,
    output logic [SIZE_W-1:0] ax_size,
    output logic [LEN_W-1:0]  ax_len,
    output logic              ax_write,
    output logic              w_valid,
    input  logic              w_ready,
    output logic [BYTES-1:0]  w_strb,
    output logic              w_last
);

    typedef struct packed {
        state_e            st;
        logic [ADDR_W-1:0] addr;
        logic [REM_W-1:0]  rem;
        logic [BEAT_W-1:0] wcnt;
        logic [SIZE_W-1:0] size;
        logic [BYTES-1:0]  strb;
        logic              wr;
        logic              err;
    } regs_t;

    regs_t q, d;

    logic [BEAT_W-1:0] beats_now;
    logic [ADDR_W-1:0] step;

    // Beats of the burst at the head of the remaining run.
    always_comb begin
        if (q.rem >= REM_W'(MAX_BEATS)) begin
            beats_now = BEAT_W'(MAX_BEATS);
        end else begin
            beats_now = BEAT_W'(q.rem);
        end
        step = ADDR_W'(beats_now) << OFS_W;
    end

    always_comb begin
        d     = q;
        d.err = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (chk_ok) begin
                        d.st   = ST_ADDR;
                        d.addr = req_addr;
                        d.rem  = chk_words;
                        d.size = chk_size;
                        d.strb = chk_strb;
                        d.wr   = req_write;
                    end else begin
                        d.err  = 1'b1;
                    end
                end
            end
            ST_ADDR: begin
                if (ax_ready) begin
                    d.addr = q.addr + step;
                    d.rem  = q.rem - REM_W'(beats_now);
                    d.wcnt = beats_now;
                    if (q.wr) begin
                        d.st = ST_DATA;
                    end else if (d.rem == '0) begin
                        d.st = ST_IDLE;
                    end
                end
            end
            ST_DATA: begin
                if (w_ready) begin
                    d.wcnt = q.wcnt - BEAT_W'(1);
                    if (q.wcnt == BEAT_W'(1)) begin
                        d.st = (q.rem == '0) ? ST_IDLE : ST_ADDR;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == ST_IDLE);
    assign req_err   = q.err;
    assign ax_valid  = (q.st == ST_ADDR);
    assign ax_addr   = q.addr;
    assign ax_burst  = BURST_INCR;
    assign ax_size   = q.size;
    assign ax_len    = LEN_W'(beats_now) - LEN_W'(1);
    assign ax_write  = q.wr;
    assign w_valid   = (q.st == ST_DATA);
    assign w_strb    = q.strb;
    assign w_last    = w_valid && (q.wcnt == BEAT_W'(1));

endmodule

// File: rtl/periph_burst_splitter.sv
module periph_burst_splitter
    import splitter_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BYTES     = 4,
    parameter int MAX_WORDS = 8,
    parameter int MAX_BEATS = 2,
    parameter int CNT_W     = 4,
    parameter int LEN_W     = 4,
    parameter int SIZE_W    = 3,
    localparam int OFS_W    = $clog2(BYTES),
    localparam int REM_W    = $clog2(MAX_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_kind,
    input  logic [CNT_W-1:0]  req_count,
    input  logic              req_write,
    output logic              req_err,
    output logic              ax_valid,
    input  logic              ax_ready,
    output logic [ADDR_W-1:0] ax_addr,
    output logic [1:0]        ax_burst,
    output logic [SIZE_W-1:0] ax_size,
    output logic [LEN_W-1:0]  ax_len,
    output logic              ax_write,
    output logic              w_valid,
    input  logic              w_ready,
    output logic [BYTES-1:0]  w_strb,
    output logic              w_last
);

    logic              chk_ok;
    logic [SIZE_W-1:0] chk_size;
    logic [BYTES-1:0]  chk_strb;
    logic [REM_W-1:0]  chk_words;

    splitter_req_check #(
        .BYTES(BYTES), .MAX_WORDS(MAX_WORDS), .CNT_W(CNT_W), .SIZE_W(SIZE_W)
    ) u_check (
        .ofs   (req_addr[OFS_W-1:0]),
        .kind  (kind_e'(req_kind)),
        .count (req_count),
        .ok    (chk_ok),
        .size  (chk_size),
        .strb  (chk_strb),
        .words (chk_words)
    );

    splitter_fsm #(
        .ADDR_W(ADDR_W), .BYTES(BYTES), .MAX_WORDS(MAX_WORDS),
        .MAX_BEATS(MAX_BEATS), .LEN_W(LEN_W), .SIZE_W(SIZE_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .chk_ok    (chk_ok),
        .chk_size  (chk_size),
        .chk_strb  (chk_strb),
        .chk_words (chk_words),
        .req_ready (req_ready),
        .req_err   (req_err),
        .ax_valid  (ax_valid),
        .ax_ready  (ax_ready),
        .ax_addr   (ax_addr),
        .ax_burst  (ax_burst),
        .ax_size   (ax_size),
        .ax_len    (ax_len),
        .ax_write  (ax_write),
        .w_valid   (w_valid),
        .w_ready   (w_ready),
        .w_strb    (w_strb),
        .w_last    (w_last)
    );

endmodule

// File: rtl/splitter_checker.sv
module splitter_checker
    import splitter_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BYTES     = 4,
    parameter int LEN_W     = 4,
    parameter int SIZE_W    = 3,
    parameter int MAX_BEATS = 2,
    localparam int OFS_W    = $clog2(BYTES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              req_err,
    input logic              ax_valid,
    input logic              ax_ready,
    input logic [ADDR_W-1:0] ax_addr,
    input logic [1:0]        ax_burst,
    input logic [SIZE_W-1:0] ax_size,
    input logic [LEN_W-1:0]  ax_len,
    input logic              ax_write,
    input logic              w_valid,
    input logic              w_ready,
    input logic [BYTES-1:0]  w_strb,
    input logic              w_last
);

    a_r1_incr_short: assert property (@(posedge clk) disable iff (!rst_n)
        ax_valid |-> (ax_burst == BURST_INCR) && (ax_len < LEN_W'(MAX_BEATS)));

    a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (ax_valid && ax_size == SIZE_W'(OFS_W)) |-> (ax_addr[OFS_W-1:0] == '0));

    a_r4_half_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (ax_valid && ax_size == SIZE_W'(1)) |-> (ax_addr[0] == 1'b0));

    a_r5_sub_single: assert property (@(posedge clk) disable iff (!rst_n)
        (ax_valid && ax_size < SIZE_W'(OFS_W)) |-> (ax_len == '0));

    a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ax_valid && !ax_ready) |=>
            ax_valid && $stable(ax_addr) && $stable(ax_len) && $stable(ax_size));

    a_r3_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (w_valid && !w_ready) |=> w_valid && $stable(w_strb) && $stable(w_last));

    a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(ax_valid && w_valid));

    a_r8_write_data: assert property (@(posedge clk) disable iff (!rst_n)
        (ax_valid && ax_ready && ax_write) |=> w_valid);

    a_r8_read_nodata: assert property (@(posedge clk) disable iff (!rst_n)
        (ax_valid && ax_ready && !ax_write) |=> !w_valid);

    a_r8_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !ax_valid && !w_valid);

    a_r6_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> req_ready && !ax_valid && !w_valid);

endmodule

bind periph_burst_splitter splitter_checker #(
    .ADDR_W(ADDR_W), .BYTES(BYTES), .LEN_W(LEN_W),
    .SIZE_W(SIZE_W), .MAX_BEATS(MAX_BEATS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .req_err   (req_err),
    .ax_valid  (ax_valid),
    .ax_ready  (ax_ready),
    .ax_addr   (ax_addr),
    .ax_burst  (ax_burst),
    .ax_size   (ax_size),
    .ax_len    (ax_len),
    .ax_write  (ax_write),
    .w_valid   (w_valid),
    .w_ready   (w_ready),
    .w_strb    (w_strb),
    .w_last    (w_last)
);

// File: tb/tb_periph_burst_splitter.sv
`timescale 1ns/1ps
module tb_periph_burst_splitter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_kind = '0;
    logic [3:0]  req_count = '0;
    logic        req_write = 1'b0;
    logic        req_err;
    logic        ax_valid;
    logic        ax_ready = 1'b0;
    logic [31:0] ax_addr;
    logic [1:0]  ax_burst;
    logic [2:0]  ax_size;
    logic [3:0]  ax_len;
    logic        ax_write;
    logic        w_valid;
    logic        w_ready = 1'b0;
    logic [3:0]  w_strb;
    logic        w_last;

    int vec = 0;
    int bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    periph_burst_splitter dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_kind(req_kind), .req_count(req_count),
        .req_write(req_write), .req_err(req_err), .ax_valid(ax_valid),
        .ax_ready(ax_ready), .ax_addr(ax_addr), .ax_burst(ax_burst),
        .ax_size(ax_size), .ax_len(ax_len), .ax_write(ax_write),
        .w_valid(w_valid), .w_ready(w_ready), .w_strb(w_strb), .w_last(w_last)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit legal(input logic [31:0] a, input logic [1:0] k, input int n);
        case (k)
            2'b00:   return (a[1:0] == 2'b00) && (n >= 1) && (n <= 8);
            2'b01:   return (a[0] == 1'b0);
            2'b10:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [3:0] exp_strb(input logic [31:0] a, input logic [1:0] k);
        case (k)
            2'b00:   return 4'b1111;
            2'b01:   return a[1] ? 4'b1100 : 4'b0011;
            default: return 4'b0001 << a[1:0];
        endcase
    endfunction

    function automatic logic [2:0] exp_size(input logic [1:0] k);
        case (k)
            2'b00:   return 3'b010;
            2'b01:   return 3'b001;
            default: return 3'b000;
        endcase
    endfunction

    function automatic string kreq(input logic [1:0] k);
        case (k)
            2'b00:   return "R2";
            2'b01:   return "R4";
            default: return "R5";
        endcase
    endfunction

    function automatic string sreq(input logic [1:0] k);
        case (k)
            2'b00:   return "R3";
            2'b01:   return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic do_req(input logic [31:0] a, input logic [1:0] k, input int n,
                          input bit wr, input int pct);
        int nb, bi, wb, beats, guard;
        bit in_data, pend;
        logic [31:0] pa, ea;
        @(negedge clk);
        chk("R8", "req_ready before request", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_addr = a; req_kind = k;
        req_count = n[3:0]; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        if (!legal(a, k, n)) begin
            chk("R6", "req_err after refused", 64'(req_err), 64'd1);
            chk("R6", "ax_valid after refused", 64'(ax_valid), 64'd0);
            @(negedge clk);
            chk("R6", "req_err one cycle only", 64'(req_err), 64'd0);
            chk("R6", "ax_valid stays low", 64'(ax_valid), 64'd0);
            chk("R6", "w_valid stays low", 64'(w_valid), 64'd0);
            return;
        end
        chk("R6", "req_err on legal", 64'(req_err), 64'd0);
        nb = (k == 2'b00) ? (n + 1) / 2 : 1;
        bi = 0; wb = 0; in_data = 0; pend = 0; guard = 0; pa = '0;
        while (bi < nb && guard < 200) begin
            beats = (k == 2'b00 && (n - 2 * bi) >= 2) ? 2 : 1;
            ea = a + 32'(8 * bi);
            if (pend) begin
                chk("R7", "ax_valid held", 64'(ax_valid), 64'd1);
                chk("R7", "ax_addr held", 64'(ax_addr), 64'(pa));
            end
            ax_ready = ($urandom % 100) < pct;
            w_ready  = ($urandom % 100) < pct;
            if (!wr) chk("R8", "no data on read", 64'(w_valid), 64'd0);
            pend = ax_valid && !ax_ready;
            pa = ax_addr;
            if (ax_valid && ax_ready) begin
                chk("R7", "address while data pending", 64'(in_data), 64'd0);
                chk(kreq(k), "ax_addr", 64'(ax_addr), 64'(ea));
                chk("R1", "ax_len", 64'(ax_len), 64'(beats - 1));
                chk("R1", "ax_burst", 64'(ax_burst), 64'd1);
                chk(kreq(k), "ax_size", 64'(ax_size), 64'(exp_size(k)));
                chk("R8", "ax_write", 64'(ax_write), 64'(wr));
                if (wr) begin
                    in_data = 1; wb = 0;
                end else begin
                    bi++;
                end
            end
            if (w_valid && w_ready) begin
                chk("R7", "data after address", 64'(in_data), 64'd1);
                chk(sreq(k), "w_strb", 64'(w_strb), 64'(exp_strb(a, k)));
                chk("R3", "w_last", 64'(w_last), 64'(wb == beats - 1));
                if (wb == beats - 1) begin
                    bi++; in_data = 0;
                end else begin
                    wb++;
                end
            end
            @(negedge clk);
            guard++;
        end
        chk("R7", "request completes", 64'(guard < 200), 64'd1);
        ax_ready = 1'b0; w_ready = 1'b0;
        chk("R8", "req_ready after run", 64'(req_ready), 64'd1);
        chk("R8", "ax_valid after run", 64'(ax_valid), 64'd0);
    endtask

    initial begin
        logic [31:0] a;
        logic [1:0]  k;
        int          r, n;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        chk("R9", "req_ready in reset", 64'(req_ready), 64'd1);
        chk("R9", "ax_valid in reset", 64'(ax_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", "ax_valid after reset", 64'(ax_valid), 64'd0);
        chk("R9", "w_valid after reset", 64'(w_valid), 64'd0);
        chk("R9", "req_err after reset", 64'(req_err), 64'd0);

        do_req(32'h0000_0000, 2'b00, 8, 1'b1, 100);
        do_req(32'h0000_0000, 2'b00, 8, 1'b1, 40);
        do_req(32'h0000_0000, 2'b00, 3, 1'b0, 100);
        do_req(32'h0000_0000, 2'b00, 3, 1'b1, 50);
        do_req(32'h0000_0008, 2'b00, 1, 1'b1, 100);
        do_req(32'h0000_0000, 2'b01, 5, 1'b1, 100);
        do_req(32'h0000_0006, 2'b01, 0, 1'b1, 60);
        do_req(32'h0000_000B, 2'b10, 9, 1'b1, 100);
        do_req(32'h0000_0008, 2'b10, 1, 1'b0, 100);
        do_req(32'hFFFF_FFF8, 2'b00, 4, 1'b1, 70);
        do_req(32'h0000_0001, 2'b01, 1, 1'b1, 100);
        do_req(32'h0000_0002, 2'b00, 2, 1'b1, 100);
        do_req(32'h0000_0010, 2'b00, 0, 1'b0, 100);
        do_req(32'h0000_0010, 2'b00, 9, 1'b1, 100);
        do_req(32'h0000_0010, 2'b11, 1, 1'b1, 100);

        for (int i = 0; i < 400; i++) begin
            r = $urandom % 10;
            k = (r < 5) ? 2'b00 : (r < 7) ? 2'b01 : (r < 9) ? 2'b10 : 2'b11;
            a = $urandom;
            if (($urandom % 4) != 0) begin
                if (k == 2'b00) a[1:0] = 2'b00;
                if (k == 2'b01) a[0] = 1'b0;
            end
            n = (k == 2'b00) ? int'($urandom % 10) : int'($urandom % 16);
            do_req(a, k, n, 1'($urandom % 2), 30 + int'($urandom % 71));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

endmodule